// File: doc/BRIEF.md
# Serial-Bus Byte Memory Controller with Layered Write Protection

This block is an SPI slave (mode 0: data sampled on the rising clock edge, changed on the falling edge, most significant bit first) in front of a 512-byte storage array held in registers. A host selects the block with an active-low select line and sends a one-byte command, then an address and data as the command needs. Commands set or clear a write-enable latch, read or write a small status register, read bytes sequentially from any address, and write up to a page of 16 bytes in one transaction. The SPI clock and data lines are oversampled by the system clock, so the SPI clock must stay well below a quarter of the system clock rate.

A write is buffered during the transaction and committed only when select is released on a byte boundary. Three independent guards decide whether it lands. The write-enable latch must be set, the write-protect input must be high, and each target byte must lie outside the range locked by the two-bit protection field of the status register. An accepted write starts a timed busy interval of `BUSY_TICKS` system clocks. Memory or status contents change when that interval ends, and during it only the status read is served. The host polls the busy flag to find out when the commit has finished.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 and every memory byte reads 0xFF. The status byte is {4'b0000, protect[1:0], latch, busy}, with busy in bit 0, the latch in bit 1 and the protect field in bits 3:2.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte on every following byte until select rises.
- R3: Command 0x03 reads memory. Opcode bit 3 supplies address bit 8 and the next byte supplies address bits 7:0. Data bytes follow MSB first, with the address advancing on every byte and wrapping from 511 to 0.
- R4: Command 0x02 writes a page, with the address taken as in R3. With the latch clear, the write changes no memory byte and starts no busy interval.
- R5: While the write-protect input is low, neither a page write nor a status write changes memory or status, no busy interval starts, and the latch keeps its value.
- R6: A write commits only if select rises after a whole number of bytes and, for a page write, at least one data byte was received. Otherwise nothing changes and the latch keeps its value.
- R7: Within a page write, the byte address wraps inside its aligned 16-byte page. When more than 16 bytes are sent, the later bytes overwrite the earlier ones.
- R8: A committed write clears the latch at once and raises busy for exactly `BUSY_TICKS` clocks. Memory and status take their new values when busy falls.
- R9: While busy, every command other than 0x05 is ignored. MISO returns 0x00 for such a command, and the latch is left unchanged.
- R10: The protect field locks nothing (00), addresses 0x180 to 0x1FF (01), 0x100 to 0x1FF (10) or the whole array (11). Locked bytes of a committed page write are skipped, and unlocked bytes of the same write still land.
- R11: Command 0x01 followed by one byte loads status bits 3:2 from bits 3:2 of that byte. The other bits of that byte are ignored.
- R12: MISO is low while select is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the SPI lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| wp_n | input | 1 | Write protect, active low |

## Verification
A latch stuck high or a wrong decision by a protection guard stays hidden until the next busy interval ends. It then shows as a byte that differs from the reference model on the next sequential read, so every write is followed by a read-back of its whole page. A wrong busy counter or a broken pending-commit flag appears in the very next status poll, which returns a busy or latch bit that disagrees with the expected value. Errors in the address pointer or the page offset show up as data landing one slot away. The wrap tests across 511 to 0 and across the end of a page catch these within the same read-back.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

   typedef enum logic [2:0] {
      ST_OPC,
      ST_ADR,
      ST_RDAT,
      ST_WDAT,
      ST_RSTS,
      ST_WSTS,
      ST_SKIP
   } cmd_st_t;

   localparam logic [7:0] OP_LATCH_SET = 8'h06;
   localparam logic [7:0] OP_LATCH_CLR = 8'h04;
   localparam logic [7:0] OP_STAT_RD   = 8'h05;
   localparam logic [7:0] OP_STAT_WR   = 8'h01;
   localparam logic [7:0] OP_MEM_RD    = 8'h03;
   localparam logic [7:0] OP_MEM_WR    = 8'h02;
   localparam logic [7:0] OP_AHI_MASK  = 8'h08;

   localparam logic [1:0] LOCK_NONE    = 2'b00;
   localparam logic [1:0] LOCK_QUARTER = 2'b01;
   localparam logic [1:0] LOCK_HALF    = 2'b10;
   localparam logic [1:0] LOCK_ALL     = 2'b11;

endpackage

// File: rtl/spi_nvm_shift.sv
module spi_nvm_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic       sel,
   output logic       rx_stb,
   output logic [7:0] rx_byte,
   output logic       cs_end,
   output logic       cs_aligned,
   output logic       miso
);

   logic       sck_s, sck_d, mosi_s, cs_s, cs_d;
   logic [2:0] bit_cnt;
   logic [6:0] sh;
   logic [7:0] tx_sh;
   logic       rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_s  <= 1'b0;
         sck_d  <= 1'b0;
         mosi_s <= 1'b0;
         cs_s   <= 1'b0;
         cs_d   <= 1'b0;
      end else begin
         sck_s  <= sck;
         sck_d  <= sck_s;
         mosi_s <= mosi;
         cs_s   <= ~cs_n;
         cs_d   <= cs_s;
      end
   end

   assign rise       = cs_s & sck_s & ~sck_d;
   assign fall       = cs_s & ~sck_s & sck_d;
   assign sel        = cs_s;
   assign cs_end     = cs_d & ~cs_s;
   assign cs_aligned = (bit_cnt == 3'd0);
   assign miso       = cs_s & tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sh      <= '0;
         rx_stb  <= 1'b0;
         rx_byte <= '0;
         tx_sh   <= '0;
      end else begin
         rx_stb <= 1'b0;
         if (!cs_s) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
         end else begin
            if (rise) begin
               bit_cnt <= bit_cnt + 3'd1;
               sh      <= {sh[5:0], mosi_s};
               if (bit_cnt == 3'd7) begin
                  rx_stb  <= 1'b1;
                  rx_byte <= {sh, mosi_s};
               end
            end
            if (fall) begin
               if (bit_cnt == 3'd0) tx_sh <= tx_byte;
               else                 tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spi_nvm_guard.sv
module spi_nvm_guard #(
   parameter int ADDR_W = 9
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        bp,
   output logic              locked
);
   import spi_nvm_pkg::*;

   always_comb begin
      case (bp)
         LOCK_NONE:    locked = 1'b0;
         LOCK_QUARTER: locked = (addr[ADDR_W-1 -: 2] == 2'b11);
         LOCK_HALF:    locked = addr[ADDR_W-1];
         default:      locked = 1'b1;
      endcase
   end

endmodule

// File: rtl/spi_nvm_wtimer.sv
module spi_nvm_wtimer #(
   parameter int TICKS = 1200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(TICKS);

   logic [CW-1:0] cnt;

   initial begin : chk_ticks
      assert (TICKS >= 2) else $error("spi_nvm_wtimer: TICKS must be at least 2");
   end

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         cnt  <= CW'(TICKS - 1);
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl #(
   parameter int ADDR_W     = 9,
   parameter int PAGE_BYTES = 16,
   parameter int BUSY_TICKS = 1200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   output logic miso,
   input  logic wp_n
);
   import spi_nvm_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFF_W;

   initial begin : chk_params
      assert (ADDR_W == 9) else $error("spi_nvm_ctrl: opcode carries exactly one high address bit");
      assert (PAGE_BYTES >= 2 && (1 << OFF_W) == PAGE_BYTES && PAGE_BYTES <= 256)
         else $error("spi_nvm_ctrl: PAGE_BYTES must be a power of two in 2..256");
      assert (BUSY_TICKS >= 2) else $error("spi_nvm_ctrl: BUSY_TICKS must be at least 2");
   end

   logic              sel, rx_stb, cs_end, cs_aligned;
   logic [7:0]        rx_byte, tx_byte, status;
   logic              busy, done, start;
   logic              wel, wp_s;
   logic [1:0]        bp, bp_new;
   logic              sts_got, pend_page, pend_sts;
   logic              is_rd, a_hi;
   cmd_st_t           st;
   logic [ADDR_W-1:0] ptr, addr_full;
   logic [7:0]        rd_byte;
   logic [PG_W-1:0]   pg_base;
   logic [OFF_W-1:0]  pg_off;
   logic [7:0]        pg_buf  [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] pg_vld, slot_lock;
   logic [7:0]        mem [DEPTH];
   logic              commit_page, commit_sts;

   spi_nvm_shift u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .sck        (sck),
      .mosi       (mosi),
      .tx_byte    (tx_byte),
      .sel        (sel),
      .rx_stb     (rx_stb),
      .rx_byte    (rx_byte),
      .cs_end     (cs_end),
      .cs_aligned (cs_aligned),
      .miso       (miso)
   );

   spi_nvm_wtimer #(.TICKS(BUSY_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done)
   );

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      spi_nvm_guard #(.ADDR_W(ADDR_W)) u_guard (
         .addr   ({pg_base, OFF_W'(g)}),
         .bp     (bp),
         .locked (slot_lock[g])
      );
   end

   assign status    = {4'b0000, bp, wel, busy};
   assign addr_full = {a_hi, rx_byte};

   always_comb begin
      case (st)
         ST_RSTS: tx_byte = status;
         ST_RDAT: tx_byte = rd_byte;
         default: tx_byte = 8'h00;
      endcase
   end

   assign commit_page = cs_end && cs_aligned && !busy && wel && wp_s &&
                        (st == ST_WDAT) && (|pg_vld);
   assign commit_sts  = cs_end && cs_aligned && !busy && wel && wp_s &&
                        (st == ST_WSTS) && sts_got;
   assign start       = commit_page || commit_sts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp_s <= 1'b0;
      else        wp_s <= wp_n;
   end

   // command sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OPC;
         is_rd   <= 1'b0;
         a_hi    <= 1'b0;
         ptr     <= '0;
         rd_byte <= '0;
         pg_base <= '0;
         pg_off  <= '0;
         pg_vld  <= '0;
         sts_got <= 1'b0;
         bp_new  <= '0;
         for (int i = 0; i < PAGE_BYTES; i++) pg_buf[i] <= '0;
      end else if (!sel) begin
         st <= ST_OPC;
      end else if (rx_stb) begin
         case (st)
            ST_OPC: begin
               if (busy && rx_byte != OP_STAT_RD) begin
                  st <= ST_SKIP;
               end else if (rx_byte == OP_STAT_RD) begin
                  st <= ST_RSTS;
               end else if (rx_byte == OP_STAT_WR) begin
                  st      <= ST_WSTS;
                  sts_got <= 1'b0;
               end else if ((rx_byte & ~OP_AHI_MASK) == OP_MEM_RD) begin
                  st    <= ST_ADR;
                  is_rd <= 1'b1;
                  a_hi  <= rx_byte[3];
               end else if ((rx_byte & ~OP_AHI_MASK) == OP_MEM_WR) begin
                  st     <= ST_ADR;
                  is_rd  <= 1'b0;
                  a_hi   <= rx_byte[3];
                  pg_vld <= '0;
               end else begin
                  st <= ST_SKIP;
               end
            end
            ST_ADR: begin
               if (is_rd) begin
                  rd_byte <= mem[addr_full];
                  ptr     <= addr_full + 1'b1;
                  st      <= ST_RDAT;
               end else begin
                  pg_base <= addr_full[ADDR_W-1:OFF_W];
                  pg_off  <= addr_full[OFF_W-1:0];
                  st      <= ST_WDAT;
               end
            end
            ST_RDAT: begin
               rd_byte <= mem[ptr];
               ptr     <= ptr + 1'b1;
            end
            ST_WDAT: begin
               pg_buf[pg_off] <= rx_byte;
               pg_vld[pg_off] <= 1'b1;
               pg_off         <= pg_off + 1'b1;
            end
            ST_WSTS: begin
               bp_new  <= rx_byte[3:2];
               sts_got <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   // latch, protect field and deferred commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel       <= 1'b0;
         bp        <= LOCK_NONE;
         pend_page <= 1'b0;
         pend_sts  <= 1'b0;
      end else begin
         if (sel && rx_stb && st == ST_OPC && !busy) begin
            if (rx_byte == OP_LATCH_SET) wel <= 1'b1;
            if (rx_byte == OP_LATCH_CLR) wel <= 1'b0;
         end
         if (start) begin
            wel       <= 1'b0;
            pend_page <= commit_page;
            pend_sts  <= commit_sts;
         end
         if (done) begin
            if (pend_sts) bp <= bp_new;
            pend_page <= 1'b0;
            pend_sts  <= 1'b0;
         end
      end
   end

   // storage array
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (done && pend_page) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pg_vld[i] && !slot_lock[i]) mem[{pg_base, OFF_W'(i)}] <= pg_buf[i];
         end
      end
   end

endmodule

// File: rtl/spi_nvm_chk.sv
module spi_nvm_chk #(
   parameter int BUSY_TICKS = 1200
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       miso,
   input logic       busy,
   input logic       wel,
   input logic [1:0] bp,
   input logic       wp_ok
);

   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= 0;
   end

   p_idle_miso_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !miso);

   p_latch_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));

   p_latch_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !wel);

   p_wp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wp_ok));

   p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == BUSY_TICKS));

   p_prot_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(bp));

endmodule

bind spi_nvm_ctrl spi_nvm_chk #(.BUSY_TICKS(BUSY_TICKS)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .miso  (miso),
   .busy  (busy),
   .wel   (wel),
   .bp    (bp),
   .wp_ok (wp_s)
);

// File: tb/tb_spi_nvm_ctrl.sv
module tb_spi_nvm_ctrl;

   localparam int BT   = 1200;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic mosi = 1'b0;
   logic wp_n = 1'b1;
   logic miso;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   logic [7:0] ref_mem [512];
   logic       m_wel;
   logic [1:0] m_bp;

   // scoreboard queues: driver pushes, monitor pops
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #2 clk = ~clk;

   spi_nvm_ctrl #(.BUSY_TICKS(BT)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
      .mosi(mosi), .miso(miso), .wp_n(wp_n)
   );

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic push_exp(input logic [7:0] b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   task automatic monitor_pop(input logic [7:0] got);
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check8(t, got, e);
   endtask

   task automatic xfer(input logic [7:0] d, output logic [7:0] q);
      for (int i = 7; i >= 0; i--) begin
         mosi = d[i];
         repeat (HALF) @(negedge clk);
         q[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xbits(input int n);
      for (int i = 0; i < n; i++) begin
         mosi = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic sel_on();
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sel_off();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   function automatic bit locked(input int a, input logic [1:0] bp);
      case (bp)
         2'b00:   return 0;
         2'b01:   return a >= 'h180;
         2'b10:   return a >= 'h100;
         default: return 1;
      endcase
   endfunction

   task automatic cmd1(input logic [7:0] op, input bit idle);
      logic [7:0] q;
      sel_on(); xfer(op, q); sel_off();
      if (idle && op == 8'h06) m_wel = 1;
      if (idle && op == 8'h04) m_wel = 0;
   endtask

   task automatic status_is(input logic [7:0] exp, input string tag);
      logic [7:0] q;
      sel_on();
      xfer(8'h05, q);
      push_exp(exp, tag);
      xfer(8'h00, q);
      monitor_pop(q);
      sel_off();
   endtask

   task automatic read_seq(input int addr, input int n, input string tag);
      logic [7:0] q;
      int a;
      a = addr;
      sel_on();
      xfer({4'b0000, 1'(addr >> 8), 3'b011}, q);
      xfer(8'(addr), q);
      for (int i = 0; i < n; i++) begin
         push_exp(ref_mem[a], tag);
         xfer(8'h00, q);
         monitor_pop(q);
         a = (a + 1) % 512;
      end
      sel_off();
   endtask

   task automatic write_page(input int addr, input int n, input logic [7:0] seed,
                             input bit aligned, output bit took);
      logic [7:0] q;
      logic [7:0] d;
      int base, off;
      base = addr & 'h1F0;
      off  = addr & 'hF;
      sel_on();
      xfer({4'b0000, 1'(addr >> 8), 3'b010}, q);
      xfer(8'(addr), q);
      for (int i = 0; i < n; i++) xfer(seed + 8'(i * 13), q);
      if (!aligned) xbits(3);
      sel_off();
      took = aligned && n > 0 && m_wel && wp_n;
      if (took) begin
         for (int i = 0; i < n; i++) begin
            d = seed + 8'(i * 13);
            if (!locked(base + ((off + i) % 16), m_bp)) ref_mem[base + ((off + i) % 16)] = d;
         end
         m_wel = 0;
      end
   endtask

   task automatic write_status(input logic [7:0] v, output bit took);
      logic [7:0] q;
      sel_on(); xfer(8'h01, q); xfer(v, q); sel_off();
      took = m_wel && wp_n;
      if (took) m_wel = 0;
   endtask

   task automatic wait_idle();
      repeat (BT + 60) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      bit took;
      logic [7:0] q;
      logic [1:0] nbp;
      for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
      m_wel = 0;
      m_bp  = 2'b00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state and status layout
      status_is(8'h00, "R1 status after reset");
      read_seq(0, 2, "R1 memory after reset");
      // R12 idle output
      check8("R12 miso idle", {7'b0, miso}, 8'h00);

      // R2 latch set and clear
      cmd1(8'h06, 1);
      status_is(8'h02, "R2 latch set");
      cmd1(8'h04, 1);
      status_is(8'h00, "R2 latch cleared");

      // R4 write without latch
      write_page('h010, 1, 8'h5A, 1, took);
      status_is(8'h00, "R4 no busy without latch");
      read_seq('h010, 1, "R4 memory untouched");

      // R8 commit, R7 page wrap, R9 busy lockout
      cmd1(8'h06, 1);
      write_page('h1FE, 4, 8'hA0, 1, took);
      status_is(8'h01, "R8 busy raised latch cleared");
      cmd1(8'h06, 0);
      status_is(8'h01, "R9 latch set ignored while busy");
      sel_on();
      xfer(8'h0B, q); xfer(8'hFE, q); xfer(8'h00, q);
      sel_off();
      check8("R9 read ignored while busy", q, 8'h00);
      wait_idle();
      status_is(8'h00, "R8 busy ended");
      // R3 continuous read wrapping 511 to 0
      read_seq('h1FE, 4, "R3 read wrap");
      read_seq('h1F0, 2, "R7 page wrap landing");

      // R7 overlong page
      cmd1(8'h06, 1);
      write_page('h020, 20, 8'h11, 1, took);
      wait_idle();
      read_seq('h020, 16, "R7 overwrite within page");

      // R6 misaligned release and empty write
      cmd1(8'h06, 1);
      write_page('h030, 2, 8'h77, 0, took);
      status_is(8'h02, "R6 misaligned no commit");
      write_page('h030, 0, 8'h77, 1, took);
      status_is(8'h02, "R6 empty write no commit");
      read_seq('h030, 2, "R6 memory untouched");

      // R5 write protect pin
      wp_n = 1'b0;
      repeat (4) @(negedge clk);
      write_page('h040, 1, 8'h33, 1, took);
      status_is(8'h02, "R5 page write blocked");
      write_status(8'h0C, took);
      status_is(8'h02, "R5 status write blocked");
      wp_n = 1'b1;
      repeat (4) @(negedge clk);
      read_seq('h040, 1, "R5 memory untouched");

      // R11 status write, R10 quarter lock
      write_status(8'hF4, took);
      nbp = 2'b01;
      status_is({4'b0, m_bp, 2'b01}, "R11 old field kept during busy");
      wait_idle();
      m_bp = nbp;
      status_is(8'h04, "R11 field loaded other bits ignored");
      cmd1(8'h06, 1);
      write_page('h180, 2, 8'h41, 1, took);
      wait_idle();
      read_seq('h180, 2, "R10 quarter locked");
      cmd1(8'h06, 1);
      write_page('h170, 2, 8'h52, 1, took);
      wait_idle();
      read_seq('h170, 2, "R10 below quarter writable");

      // R10 half lock
      cmd1(8'h06, 1);
      write_status(8'h08, took);
      wait_idle();
      m_bp = 2'b10;
      status_is(8'h08, "R10 half field");
      cmd1(8'h06, 1);
      write_page('h100, 2, 8'h63, 1, took);
      wait_idle();
      read_seq('h100, 2, "R10 half locked");
      cmd1(8'h06, 1);
      write_page('h0F0, 2, 8'h74, 1, took);
      wait_idle();
      read_seq('h0F0, 2, "R10 below half writable");

      // R10 whole array lock
      cmd1(8'h06, 1);
      write_status(8'h0C, took);
      wait_idle();
      m_bp = 2'b11;
      status_is(8'h0C, "R10 all field");
      cmd1(8'h06, 1);
      write_page('h000, 2, 8'h85, 1, took);
      wait_idle();
      read_seq('h000, 2, "R10 all locked");
      status_is(8'h0C, "R8 latch cleared after locked write");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule